// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block holds the bytes a serial receiver has decoded until software or a DMA engine reads them. Incoming bytes arrive as single-cycle strobes and are kept in first-in, first-out order in a 64-entry store. The block reports empty, full and a programmable fill trigger. When a byte arrives at a full queue, the byte is dropped and an overrun event is pulsed.

An idle timer counts down from four character times and is restarted by every byte the queue accepts. When the count runs out and the timeout setting is nonzero, a timeout event is pulsed. The block derives the character time from the bit period and the frame format. A flush request empties the queue. The request stays visible as a pending flag for one cycle and then clears itself. The serial deserialiser and interrupt aggregation sit outside this block.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0, `trig_hit`=0 (trigger setting 32), both event pulses are 0 and `flush_pending`=0.
- R2: A push or pop is ignored while `rx_disable`=1 or `rx_enable`=0. `level` and `pop_data` keep their values.
- R3: Bytes are returned in arrival order. `pop_data` is registered and shows the popped byte on the cycle after the pop. `full` rises at 64 entries and `level` never exceeds 64.
- R4: A push while `full`=1 stores nothing. `overrun_pulse` is high for exactly one cycle, in the cycle after that push.
- R5: A pop while empty sets `pop_data` to 0 and leaves `level` at 0.
- R6: `trig_hit` is 1 exactly when `level` >= the trigger setting. The trigger setting is written through `trig_we`/`trig_wdata`.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full leave `level` unchanged.
- R8: Each accepted push reloads the idle timer with 4 character times, counted in clock cycles. `timeout_pulse` is high in the cycle that follows exactly that many clock edges after the last accepted push, and only if the timeout setting (`tout_we`/`tout_wdata`, reset 0) is nonzero.
- R9: One character time is `bit_period` × (1 start + data bits + parity + stop bits). The data-bit count follows `data_sel`: 0 gives 8, 1 gives 7, 2 gives 6 and 3 gives 8. `parity_en`=1 adds 1 bit. `two_stop`=1 gives 2 stop bits, otherwise 1.
- R10: A `flush_req` pulse sets `flush_pending` in the next cycle. In the cycle after that the queue is empty (`level`=0) and `flush_pending` has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive path enable |
| rx_disable | input | 1 | Receive path disable (overrides enable) |
| push_valid | input | 1 | Received byte strobe |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Read one byte |
| pop_data | output | 8 | Byte read by the previous pop |
| flush_req | input | 1 | Receive reset request |
| flush_pending | output | 1 | Self-clearing reset bit readback |
| trig_we | input | 1 | Write trigger setting |
| trig_wdata | input | 7 | New trigger setting |
| tout_we | input | 1 | Write timeout setting |
| tout_wdata | input | 8 | New timeout setting (nonzero enables) |
| bit_period | input | 12 | Clock cycles per serial bit |
| data_sel | input | 2 | Data-bit count select |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| level | output | 7 | Occupancy |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| trig_hit | output | 1 | Occupancy at or above trigger |
| overrun_pulse | output | 1 | Dropped-byte event |
| timeout_pulse | output | 1 | Idle timeout event |

## Verification
The assertions assume that `rx_enable`, `rx_disable` and the format inputs are stable at clock edges. They also assume that `bit_period` and the frame format do not change while the timer is counting, because the timer only reads them when it reloads. The stimulus changes every input on the falling edge and changes the format only while the timer is idle. It reads the outputs on the following falling edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W = 8;

  // Frame bits: start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [1:0] dsel,
                                            input logic       par,
                                            input logic       two_stop);
    logic [3:0] dbits;
    case (dsel)
      2'd1:    dbits = 4'd7;
      2'd2:    dbits = 4'd6;
      default: dbits = 4'd8;
    endcase
    return 4'd1 + dbits + {3'd0, par} + (two_stop ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/rxq_chartime.sv
module rxq_chartime #(
  parameter int PERIOD_W = 12,
  localparam int CHAR_W  = PERIOD_W + 4
) (
  input  logic [PERIOD_W-1:0] bit_period,
  input  logic [1:0]          data_sel,
  input  logic                parity_en,
  input  logic                two_stop,
  output logic [CHAR_W-1:0]   char_cycles
);
  logic [3:0] nbits;

  always_comb begin
    nbits       = rxq_pkg::frame_bits(data_sel, parity_en, two_stop);
    char_cycles = CHAR_W'(bit_period) * CHAR_W'(nbits);
  end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  input  logic             fire_en,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (restart) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      fire_d = (cnt_q == CNT_W'(1)) && fire_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fire  <= fire_d;
    end
  end

  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !fire);
  assert_fire_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              accept,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     lvl_d;
  logic [DATA_W-1:0] pop_d;
  logic              take;

  assign empty = (level == '0);
  assign full  = (level == CW'(DEPTH));

  always_comb begin
    accept = push_ok && !full && !clear;
    drop   = push_ok && full && !clear;
    take   = pop_ok && !empty && !clear;
    wr_d   = wr_q;
    rd_d   = rd_q;
    lvl_d  = level;
    pop_d  = pop_data;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (accept) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (take)   rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({accept, take})
        2'b10:   lvl_d = level + 1'b1;
        2'b01:   lvl_d = level - 1'b1;
        default: lvl_d = level;
      endcase
      if (pop_ok) pop_d = take ? mem[rd_q] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      rd_q     <= '0;
      level    <= '0;
      pop_data <= '0;
    end else begin
      wr_q     <= wr_d;
      rd_q     <= rd_d;
      level    <= lvl_d;
      pop_data <= pop_d;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && empty && !clear) |=> (pop_data == '0) && (level <= CW'(1)));
  assert_drop_keeps_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop_ok) |=> (level == CW'(DEPTH)));
  assert_pushpop_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !empty && !full && !clear) |=> $stable(level));
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH      = 64,
  parameter int PERIOD_W   = 12,
  parameter int TOUT_W     = 8,
  parameter int TRIG_RESET = 32,
  localparam int DW        = rxq_pkg::BYTE_W,
  localparam int CW        = $clog2(DEPTH) + 1,
  localparam int CHAR_W    = PERIOD_W + 4,
  localparam int TMR_W     = CHAR_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_enable,
  input  logic                rx_disable,
  input  logic                push_valid,
  input  logic [DW-1:0]       push_data,
  input  logic                pop_req,
  output logic [DW-1:0]       pop_data,
  input  logic                flush_req,
  output logic                flush_pending,
  input  logic                trig_we,
  input  logic [CW-1:0]       trig_wdata,
  input  logic                tout_we,
  input  logic [TOUT_W-1:0]   tout_wdata,
  input  logic [PERIOD_W-1:0] bit_period,
  input  logic [1:0]          data_sel,
  input  logic                parity_en,
  input  logic                two_stop,
  output logic [CW-1:0]       level,
  output logic                empty,
  output logic                full,
  output logic                trig_hit,
  output logic                overrun_pulse,
  output logic                timeout_pulse
);
  logic              path_on;
  logic              accept, drop;
  logic [CW-1:0]     trig_q, trig_d;
  logic [TOUT_W-1:0] tout_q, tout_d;
  logic              pend_d, ovr_d;
  logic [CHAR_W-1:0] char_cycles;
  logic [TMR_W-1:0]  idle_load;

  assign path_on = rx_enable && !rx_disable;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush_pending),
    .push_ok   (push_valid && path_on),
    .pop_ok    (pop_req && path_on),
    .push_data (push_data),
    .pop_data  (pop_data),
    .level     (level),
    .empty     (empty),
    .full      (full),
    .accept    (accept),
    .drop      (drop)
  );

  rxq_chartime #(.PERIOD_W(PERIOD_W)) u_char (
    .bit_period  (bit_period),
    .data_sel    (data_sel),
    .parity_en   (parity_en),
    .two_stop    (two_stop),
    .char_cycles (char_cycles)
  );

  assign idle_load = {char_cycles, 2'b00};

  rxq_timer #(.CNT_W(TMR_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (accept),
    .load_val (idle_load),
    .fire_en  (tout_q != '0),
    .fire     (timeout_pulse)
  );

  always_comb begin
    trig_d = trig_we ? trig_wdata : trig_q;
    tout_d = tout_we ? tout_wdata : tout_q;
    pend_d = flush_req && !flush_pending;
    ovr_d  = drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q        <= CW'(TRIG_RESET);
      tout_q        <= '0;
      flush_pending <= 1'b0;
      overrun_pulse <= 1'b0;
    end else begin
      trig_q        <= trig_d;
      tout_q        <= tout_d;
      flush_pending <= pend_d;
      overrun_pulse <= ovr_d;
    end
  end

  assign trig_hit = (level >= trig_q);

  assert_overrun_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_pulse |-> $past(full));
  assert_gated_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_on && !flush_pending) |=> $stable(level) && $stable(pop_data));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pending |=> (level == '0) && !flush_pending);
  assert_timeout_needs_setting_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> ($past(tout_q) != '0));
  assert_trig_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_hit) |-> (level > $past(level)) || (trig_q != $past(trig_q)));
endmodule

// File: tb/rx_trig_fifo_test.sv
`timescale 1ns/1ps
module rx_trig_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_enable, rx_disable, push_valid, pop_req, flush_req;
  logic [7:0] push_data, pop_data;
  logic       flush_pending, trig_we, tout_we;
  logic [6:0] trig_wdata, level;
  logic [7:0] tout_wdata;
  logic [11:0] bit_period;
  logic [1:0] data_sel;
  logic       parity_en, two_stop;
  logic       empty, full, trig_hit, overrun_pulse, timeout_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rx_trig_fifo uut (.*);

  // {push, data, pop, exp_level, chk_pop, exp_pop}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'hA5, 1'b0, 7'd1, 1'b0, 8'h00},
    {1'b1, 8'h3C, 1'b0, 7'd2, 1'b0, 8'h00},
    {1'b1, 8'h7E, 1'b0, 7'd3, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 7'd2, 1'b1, 8'hA5},
    {1'b1, 8'h11, 1'b1, 7'd2, 1'b1, 8'h3C},
    {1'b0, 8'h00, 1'b1, 7'd1, 1'b1, 8'h7E},
    {1'b0, 8'h00, 1'b1, 7'd0, 1'b1, 8'h11},
    {1'b0, 8'h00, 1'b1, 7'd0, 1'b1, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic [7:0] d, input logic r);
    push_valid = p; push_data = d; pop_req = r;
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int pulses;
    int bad;
    rst_n = 1'b0; rx_enable = 1'b1; rx_disable = 1'b0;
    push_valid = 1'b0; push_data = '0; pop_req = 1'b0; flush_req = 1'b0;
    trig_we = 1'b0; trig_wdata = '0; tout_we = 1'b0; tout_wdata = '0;
    bit_period = 12'd3; data_sel = 2'd0; parity_en = 1'b1; two_stop = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 level", level, 0);
    chk("R1 trig_hit", trig_hit, 0);
    chk("R1 pulses", overrun_pulse | timeout_pulse | flush_pending, 0);

    // Vector walk: ordering R3, simultaneous R7, empty pop R5
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][25], VEC[i][24:17], VEC[i][16]);
      chk($sformatf("R3/R7 level vec%0d", i), level, int'(VEC[i][15:9]));
      if (VEC[i][8]) chk($sformatf("R3/R5 data vec%0d", i), pop_data, int'(VEC[i][7:0]));
    end

    // R2 gating
    rx_enable = 1'b0;
    cyc(1'b1, 8'h55, 1'b0);
    chk("R2 push while not enabled", level, 0);
    rx_enable = 1'b1; rx_disable = 1'b1;
    cyc(1'b1, 8'h55, 1'b0);
    chk("R2 push while disabled", level, 0);
    rx_disable = 1'b0;
    cyc(1'b1, 8'h66, 1'b0);
    rx_disable = 1'b1;
    cyc(1'b0, 8'h00, 1'b1);
    chk("R2 pop while disabled level", level, 1);
    chk("R2 pop while disabled data", pop_data, 0);
    rx_disable = 1'b0;
    cyc(1'b0, 8'h00, 1'b1);
    chk("R2 pop after re-enable", pop_data, 8'h66);

    // R6 trigger, R3 fill, R4 overrun
    trig_we = 1'b1; trig_wdata = 7'd5;
    @(negedge clk);
    trig_we = 1'b0;
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 8'(i + 1), 1'b0);
      if (i == 3) chk("R6 trig below", trig_hit, 0);
      if (i == 4) chk("R6 trig at level", trig_hit, 1);
      if (i == 62) chk("R3 not full at 63", full, 0);
    end
    chk("R3 full at 64", full, 1);
    chk("R3 level 64", level, 64);
    chk("R4 no overrun yet", overrun_pulse, 0);
    cyc(1'b1, 8'hEE, 1'b0);
    chk("R4 overrun pulse", overrun_pulse, 1);
    chk("R4 level held", level, 64);
    @(negedge clk);
    chk("R4 pulse one cycle", overrun_pulse, 0);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      cyc(1'b0, 8'h00, 1'b1);
      if (pop_data != 8'(i + 1)) bad++;
    end
    chk("R3/R4 order, dropped byte absent", bad, 0);
    chk("R3 empty after drain", empty, 1);

    // R10 flush
    cyc(1'b1, 8'h01, 1'b0);
    cyc(1'b1, 8'h02, 1'b0);
    cyc(1'b1, 8'h03, 1'b0);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    chk("R10 pending set", flush_pending, 1);
    @(negedge clk);
    chk("R10 level cleared", level, 0);
    chk("R10 pending self-clears", flush_pending, 0);

    // R8/R9 timeout: period 3, 8 data, parity, 2 stop -> 12 bits, 144 cycles
    tout_we = 1'b1; tout_wdata = 8'd1;
    @(negedge clk);
    tout_we = 1'b0;
    cyc(1'b1, 8'h21, 1'b0);
    pulses = 0;
    for (int i = 0; i < 143; i++) begin
      if (timeout_pulse) pulses++;
      @(negedge clk);
    end
    if (timeout_pulse) pulses++;
    chk("R9 no timeout before 4 char times", pulses, 0);
    @(negedge clk);
    chk("R8/R9 timeout at 144", timeout_pulse, 1);
    @(negedge clk);
    chk("R8 timeout one cycle", timeout_pulse, 0);

    // R8 restart: period 2, 6 data, no parity, 1 stop -> 8 bits, 64 cycles
    bit_period = 12'd2; data_sel = 2'd2; parity_en = 1'b0; two_stop = 1'b0;
    cyc(1'b1, 8'h22, 1'b0);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      if (timeout_pulse) pulses++;
      @(negedge clk);
    end
    cyc(1'b1, 8'h23, 1'b0);
    for (int i = 0; i < 63; i++) begin
      if (timeout_pulse) pulses++;
      @(negedge clk);
    end
    if (timeout_pulse) pulses++;
    chk("R8 restart delays timeout", pulses, 0);
    @(negedge clk);
    chk("R8/R9 timeout 64 after last byte", timeout_pulse, 1);

    // R8 disabled timeout setting
    tout_we = 1'b1; tout_wdata = 8'd0;
    @(negedge clk);
    tout_we = 1'b0;
    cyc(1'b1, 8'h24, 1'b0);
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      if (timeout_pulse) pulses++;
      @(negedge clk);
    end
    chk("R8 no timeout when setting zero", pulses, 0);

    done = 1;
    finish_run();
  end
endmodule